// File: doc/BRIEF.md
# UART Host Register Interface

This block is the processor-side front end of a serial port. A host reaches it through a chip select, a two-bit address, a write line and a shared eight-bit bidirectional data bus. Through that bus the host can read the last received byte, hand a byte to the transmitter, read the flag word and read or write a small control word. The block drives the bus only while a read is in progress and releases it at all other times.

The control word holds two interrupt enables, one for the receive side and one for the transmit side, and a three-bit rate selector for the bit-clock divider. A single interrupt line combines the receive conditions and the transmit condition, each under its own enable. Reading the received byte produces a one-cycle strobe that the receiver uses to clear its full and overrun flags. Writing the transmit byte produces a one-cycle load strobe. The serial engines and the rate divider sit outside this block.

Top module: `uart_host_regs`

## Requirements
- R1: After reset the control word is 0x00: both interrupt enables are 0, the rate select is 0 (the fastest rate), both strobes are 0 and the interrupt line is 0.
- R2: With chip select high, write low and address 00, the bus carries rx_byte_i in the same cycle.
- R3: A receive-byte read sampled at a clock edge makes rx_clr_o 1 for exactly the following cycle. No other access raises it.
- R4: A write with address 00 and chip select high captures the bus into txd_data_o at the clock edge and makes txd_load_o 1 for exactly the following cycle.
- R5: A read at address 01 returns the flag word with tx_empty_i in bit 7, rx_full_i in bit 6, rx_overrun_i in bit 0 and 0 in bits 5 to 1.
- R6: A write at address 01 drives nothing onto the bus, changes neither txd_data_o nor the control word, and raises no strobe.
- R7: A write at address 10 or 11 loads the control word: bit 7 is the transmit interrupt enable, bit 6 the receive interrupt enable, bits 2 to 0 the rate select. A read at either address returns that word with bits 5 to 3 as 0.
- R8: The bus is released whenever chip select is low or write is high.
- R9: irq_o is 1 when the receive interrupt enable is set and rx_full_i or rx_overrun_i is 1.
- R10: irq_o is 1 when the transmit interrupt enable is set and tx_empty_i is 1; with both enables clear irq_o is 0 whatever the flags.
- R11: With chip select low, writes and reads have no effect: no strobe, and txd_data_o and the control word keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, qualifies every access |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | 1 for write, 0 for read |
| data_io | inout | 8 | Shared host data bus, tri-state |
| tx_empty_i | input | 1 | Transmit holding register is empty |
| rx_full_i | input | 1 | Received byte is waiting |
| rx_overrun_i | input | 1 | A received byte was lost |
| rx_byte_i | input | 8 | Last received byte |
| txd_data_o | output | 8 | Transmit holding register |
| txd_load_o | output | 1 | One-cycle strobe after a transmit byte write |
| rx_clr_o | output | 1 | One-cycle strobe after a receive byte read |
| tx_ie_o | output | 1 | Transmit interrupt enable |
| rx_ie_o | output | 1 | Receive interrupt enable |
| baud_sel_o | output | 3 | Rate select for the bit-clock divider |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check that each strobe follows the access that caused it, that the two strobes never coincide, that the control word and the transmit register hold unless a selected write reaches them, and that the interrupt line agrees with the flags and enables. Only the bench scenarios show the values that come back on the bus (the flag layout, the control read-back with its zero bits, the received byte), that the bus stays released during writes and idle cycles, and that the address 01 write and the deselected accesses leave every observable output untouched.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned BAUD_W = 3;

  // flag word bit positions
  localparam int unsigned ST_TX_EMPTY = 7;
  localparam int unsigned ST_RX_FULL  = 6;
  localparam int unsigned ST_OVERRUN  = 0;

  // control word bit positions
  localparam int unsigned CT_TX_IE = 7;
  localparam int unsigned CT_RX_IE = 6;
  localparam int unsigned CT_BAUD_LSB = 0;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_RD_RX,
    ACC_WR_TX,
    ACC_RD_STAT,
    ACC_WR_NULL,
    ACC_RD_CTRL,
    ACC_WR_CTRL
  } access_e;

  typedef struct packed {
    logic              tx_ie;
    logic              rx_ie;
    logic [BAUD_W-1:0] baud;
  } ctrl_t;
endpackage

// File: rtl/uart_host_decode.sv
module uart_host_decode
  import uart_host_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          cs_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  output access_e       acc_o,
  output logic          drive_o
);
  always_comb begin
    acc_o = ACC_NONE;
    if (cs_i) begin
      unique casez ({addr_i[1:0], wr_i})
        3'b000:  acc_o = ACC_RD_RX;
        3'b001:  acc_o = ACC_WR_TX;
        3'b010:  acc_o = ACC_RD_STAT;
        3'b011:  acc_o = ACC_WR_NULL;
        3'b1?0:  acc_o = ACC_RD_CTRL;
        3'b1?1:  acc_o = ACC_WR_CTRL;
        default: acc_o = ACC_NONE;
      endcase
    end
  end

  assign drive_o = (acc_o == ACC_RD_RX) || (acc_o == ACC_RD_STAT) ||
                   (acc_o == ACC_RD_CTRL);
endmodule

// File: rtl/uart_host_ctrl_reg.sv
module uart_host_ctrl_reg
  import uart_host_pkg::*;
#(
  parameter int unsigned           DW       = DATA_W,
  parameter logic [BAUD_W-1:0]     BAUD_RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] rdata_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q.tx_ie <= 1'b0;
      ctrl_q.rx_ie <= 1'b0;
      ctrl_q.baud  <= BAUD_RST;
    end else if (we_i) begin
      ctrl_q.tx_ie <= wdata_i[CT_TX_IE];
      ctrl_q.rx_ie <= wdata_i[CT_RX_IE];
      ctrl_q.baud  <= wdata_i[CT_BAUD_LSB +: BAUD_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[CT_TX_IE] = ctrl_q.tx_ie;
    rdata_o[CT_RX_IE] = ctrl_q.rx_ie;
    rdata_o[CT_BAUD_LSB +: BAUD_W] = ctrl_q.baud;
  end

  assign ctrl_o = ctrl_q;

  // R7 R11
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctrl_q));
endmodule

// File: rtl/uart_host_txd_reg.sv
module uart_host_txd_reg
  import uart_host_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] data_o,
  output logic          load_o
);
  logic [DW-1:0] data_q;
  logic          load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= we_i;
      if (we_i) data_q <= wdata_i;
    end
  end

  assign data_o = data_q;
  assign load_o = load_q;

  // R4
  txd_load_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |-> $past(we_i));

  // R6 R11
  txd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_q |-> $stable(data_q));
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_host_pkg::*;
#(
  parameter logic [BAUD_W-1:0] BAUD_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  inout  wire  [DATA_W-1:0] data_io,
  input  logic              tx_empty_i,
  input  logic              rx_full_i,
  input  logic              rx_overrun_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic [DATA_W-1:0] txd_data_o,
  output logic              txd_load_o,
  output logic              rx_clr_o,
  output logic              tx_ie_o,
  output logic              rx_ie_o,
  output logic [BAUD_W-1:0] baud_sel_o,
  output logic              irq_o
);
  access_e           acc;
  logic              drive;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] ctrl_rd;
  logic [DATA_W-1:0] stat_rd;
  logic [DATA_W-1:0] rd_data;
  logic              rx_clr_q;

  uart_host_decode #(.AW(ADDR_W)) i_decode (
    .cs_i   (cs_i),
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .acc_o  (acc),
    .drive_o(drive)
  );

  uart_host_ctrl_reg #(.DW(DATA_W), .BAUD_RST(BAUD_RST)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (acc == ACC_WR_CTRL),
    .wdata_i(data_io),
    .ctrl_o (ctrl),
    .rdata_o(ctrl_rd)
  );

  uart_host_txd_reg #(.DW(DATA_W)) i_txd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (acc == ACC_WR_TX),
    .wdata_i(data_io),
    .data_o (txd_data_o),
    .load_o (txd_load_o)
  );

  always_comb begin
    stat_rd = '0;
    stat_rd[ST_TX_EMPTY] = tx_empty_i;
    stat_rd[ST_RX_FULL]  = rx_full_i;
    stat_rd[ST_OVERRUN]  = rx_overrun_i;
  end

  always_comb begin
    unique case (acc)
      ACC_RD_RX:   rd_data = rx_byte_i;
      ACC_RD_STAT: rd_data = stat_rd;
      ACC_RD_CTRL: rd_data = ctrl_rd;
      default:     rd_data = '0;
    endcase
  end

  assign data_io = drive ? rd_data : {DATA_W{1'bz}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_clr_q <= 1'b0;
    else         rx_clr_q <= (acc == ACC_RD_RX);
  end

  assign rx_clr_o   = rx_clr_q;
  assign tx_ie_o    = ctrl.tx_ie;
  assign rx_ie_o    = ctrl.rx_ie;
  assign baud_sel_o = ctrl.baud;

  // receive and transmit terms under separate enables
  assign irq_o = (ctrl.rx_ie & (rx_full_i | rx_overrun_i)) |
                 (ctrl.tx_ie & tx_empty_i);

  // R3
  rx_clr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clr_o |-> $past(cs_i && !wr_i && addr_i == 2'b00));

  // R3 R4
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_clr_o, txd_load_o}));

  // R4 R11
  txd_load_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txd_load_o |-> $past(cs_i && wr_i && addr_i == 2'b00));

  // R9
  irq_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ie_o && (rx_full_i || rx_overrun_i)) |-> irq_o);

  // R10
  irq_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ie_o && tx_empty_i) |-> irq_o);

  // R10
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_ie_o && !rx_ie_o) |-> !irq_o);
endmodule

// File: tb/test_uart_host_regs.sv
module test_uart_host_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0;
  logic [1:0] addr = 2'b00;
  logic       wr = 1'b0;
  logic       host_en = 1'b0;
  logic [7:0] host_val = 8'h00;
  wire  [7:0] bus;
  logic       tx_empty = 1'b0;
  logic       rx_full = 1'b0;
  logic       overrun = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [7:0] txd_data;
  logic       txd_load, rx_clr, tx_ie, rx_ie, irq;
  logic [2:0] baud;

  int checks = 0;
  int fails = 0;

  assign bus = host_en ? host_val : 8'hzz;

  always #5 clk = ~clk;

  uart_host_regs i_uart_host_regs (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .addr_i(addr), .wr_i(wr),
    .data_io(bus), .tx_empty_i(tx_empty), .rx_full_i(rx_full),
    .rx_overrun_i(overrun), .rx_byte_i(rx_byte), .txd_data_o(txd_data),
    .txd_load_o(txd_load), .rx_clr_o(rx_clr), .tx_ie_o(tx_ie),
    .rx_ie_o(rx_ie), .baud_sel_o(baud), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one-cycle write; returns strobes seen in the following cycle
  task automatic bus_write(input logic sel, input logic [1:0] a, input logic [7:0] d,
                           output logic [7:0] seen, output logic ld, output logic clr);
    @(negedge clk);
    cs = sel; addr = a; wr = 1'b1; host_en = 1'b1; host_val = d;
    #2 seen = bus;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0; host_en = 1'b0;
    ld = txd_load; clr = rx_clr;
  endtask

  task automatic bus_read(input logic sel, input logic [1:0] a,
                          output logic [7:0] d, output logic ld, output logic clr);
    @(negedge clk);
    cs = sel; addr = a; wr = 1'b0;
    #2 d = bus;
    @(negedge clk);
    cs = 1'b0;
    ld = txd_load; clr = rx_clr;
  endtask

  task automatic t_reset;
    check("R1 ctrl", {tx_ie, rx_ie, 3'b000, baud}, 8'h00);
    check("R1 strobes", {6'd0, txd_load, rx_clr}, 8'h00);
    tx_empty = 1'b1; rx_full = 1'b1; #1;
    check("R1 irq", {7'd0, irq}, 8'h00);
    tx_empty = 1'b0; rx_full = 1'b0;
  endtask

  task automatic t_rx_read;
    logic [7:0] d; logic ld, clr;
    rx_byte = 8'h3c;
    bus_read(1'b1, 2'b00, d, ld, clr);
    check("R2 rx byte", d, 8'h3c);
    check("R3 clr pulse", {7'd0, clr}, 8'h01);
    check("R3 no load", {7'd0, ld}, 8'h00);
    @(negedge clk);
    check("R3 clr one cycle", {7'd0, rx_clr}, 8'h00);
    rx_byte = 8'hc5;
    bus_read(1'b1, 2'b00, d, ld, clr);
    check("R2 rx byte 2", d, 8'hc5);
  endtask

  task automatic t_tx_write;
    logic [7:0] s; logic ld, clr;
    bus_write(1'b1, 2'b00, 8'h96, s, ld, clr);
    check("R8 no drive on tx write", s, 8'h96);
    check("R4 load pulse", {7'd0, ld}, 8'h01);
    check("R4 data", txd_data, 8'h96);
    check("R3 no clr on write", {7'd0, clr}, 8'h00);
    @(negedge clk);
    check("R4 load one cycle", {7'd0, txd_load}, 8'h00);
    bus_write(1'b1, 2'b00, 8'h01, s, ld, clr);
    check("R4 data 2", txd_data, 8'h01);
  endtask

  task automatic t_status;
    logic [7:0] d; logic ld, clr;
    tx_empty = 1'b1; rx_full = 1'b0; overrun = 1'b1;
    bus_read(1'b1, 2'b01, d, ld, clr);
    check("R5 status a", d, 8'h81);
    check("R3 no clr on status", {7'd0, clr}, 8'h00);
    tx_empty = 1'b0; rx_full = 1'b1; overrun = 1'b0;
    bus_read(1'b1, 2'b01, d, ld, clr);
    check("R5 status b", d, 8'h40);
    tx_empty = 1'b0; rx_full = 1'b0;
  endtask

  task automatic t_null_write;
    logic [7:0] s; logic ld, clr;
    tx_empty = 1'b1; rx_full = 1'b1; overrun = 1'b1;
    bus_write(1'b1, 2'b01, 8'h00, s, ld, clr);
    check("R6 bus released", s, 8'h00);
    check("R6 no strobe", {6'd0, ld, clr}, 8'h00);
    check("R6 txd kept", txd_data, 8'h01);
    check("R6 ctrl kept", {tx_ie, rx_ie, 3'b000, baud}, 8'h00);
    tx_empty = 1'b0; rx_full = 1'b0; overrun = 1'b0;
  endtask

  task automatic t_ctrl;
    logic [7:0] s, d; logic ld, clr;
    bus_write(1'b1, 2'b10, 8'hff, s, ld, clr);
    check("R7 write 10", {tx_ie, rx_ie, 3'b000, baud}, 8'hc7);
    check("R8 no drive on ctrl write", s, 8'hff);
    bus_read(1'b1, 2'b11, d, ld, clr);
    check("R7 read 11", d, 8'hc7);
    bus_write(1'b1, 2'b11, 8'h45, s, ld, clr);
    check("R7 write 11", {tx_ie, rx_ie, 3'b000, baud}, 8'h45);
    bus_read(1'b1, 2'b10, d, ld, clr);
    check("R7 read 10", d, 8'h45);
  endtask

  task automatic t_deselect;
    logic [7:0] s, d; logic ld, clr;
    bus_write(1'b0, 2'b00, 8'h77, s, ld, clr);
    check("R11 no load", {7'd0, ld}, 8'h00);
    check("R11 txd kept", txd_data, 8'h01);
    bus_write(1'b0, 2'b10, 8'h80, s, ld, clr);
    check("R11 ctrl kept", {tx_ie, rx_ie, 3'b000, baud}, 8'h45);
    rx_byte = 8'hff;
    @(negedge clk);
    cs = 1'b0; addr = 2'b00; wr = 1'b0; host_en = 1'b1; host_val = 8'h00;
    #2 d = bus;
    check("R8 released without cs", d, 8'h00);
    @(negedge clk);
    host_en = 1'b0;
    check("R11 no clr", {7'd0, rx_clr}, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] s; logic ld, clr;
    bus_write(1'b1, 2'b10, 8'h40, s, ld, clr);
    tx_empty = 1'b1; rx_full = 1'b0; overrun = 1'b0; #1;
    check("R10 tx masked", {7'd0, irq}, 8'h00);
    rx_full = 1'b1; #1;
    check("R9 rx full", {7'd0, irq}, 8'h01);
    rx_full = 1'b0; overrun = 1'b1; #1;
    check("R9 overrun", {7'd0, irq}, 8'h01);
    bus_write(1'b1, 2'b10, 8'h80, s, ld, clr);
    tx_empty = 1'b0; #1;
    check("R9 rx masked", {7'd0, irq}, 8'h00);
    tx_empty = 1'b1; #1;
    check("R10 tx empty", {7'd0, irq}, 8'h01);
    bus_write(1'b1, 2'b10, 8'h00, s, ld, clr);
    rx_full = 1'b1; #1;
    check("R10 both off", {7'd0, irq}, 8'h00);
    tx_empty = 1'b0; rx_full = 1'b0; overrun = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rx_read();
        t_tx_write();
        t_status();
        t_null_write();
        t_ctrl();
        t_deselect();
        t_irq();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule